// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sequences the low-power state of a small microcontroller core. A sleep request from the core clears the power-down flag and sets the timeout flag. It also zeroes the watchdog counter, which keeps counting, and it drops the oscillator enable. While asleep, the controller holds the I/O pins frozen and waits for one of three wake events. These are an external reset, a watchdog expiry when the watchdog is enabled, or a low level on a wake pin that is enabled both globally and on its own.

Every wake passes through a stabilization window before the core runs again. The window is a parameterized settle count, which stands in for a long fixed settle time, followed by 128 oscillator cycles. Reset-type wakes hold the core in reset through the window, so the core restarts. A pin wake keeps the core out of reset, so execution resumes at the instruction after the sleep instruction. Software reads the two flags to learn why the core woke.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: Power-up reset (rst_n low) sets pd_flag=1 and to_flag=1, drives core_run=0 and core_rst=1 and osc_en=1, and then runs a full stabilization window.
- R2: When core_run=1, sleep_req=1 and ext_rst=0 are sampled at a clock edge, the outputs after that edge show osc_en=0, core_run=0, pd_flag=0, to_flag=1 and io_hold=1.
- R3: Entering sleep zeroes the watchdog. With wdt_en=1 the watchdog keeps counting in sleep and expires at the WDT_LIMIT-th edge after the entry edge. The expiry wakes the core with core_rst=1.
- R4: pd_flag is cleared only by sleep entry and is set only by rst_n. External resets, watchdog resets and pin wakes leave it unchanged.
- R5: A watchdog expiry, asleep or running, clears to_flag and starts a reset wake. Sleep entry sets to_flag.
- R6: ext_rst=1 in any state starts a reset wake (core_rst=1, core_run=0 after the edge) and restarts the stabilization count.
- R7: A pin wake happens only when wk_glob_en=1, wk_pin_en[i]=1 and wk_pin[i]=0 for some i. Such a wake keeps core_rst=0 through the window. A low pin that lacks either enable has no effect.
- R8: core_run rises exactly SETTLE_CYC+TAIL_CYC edges after the edge that starts the window (TAIL_CYC defaults to 128).
- R9: When a reset source and a pin wake occur in the same cycle, the wake is a reset wake (core_rst=1).
- R10: io_hold=1 exactly while asleep, and osc_en=0 during the same cycles.
- R11: With wdt_en=0 no watchdog expiry occurs. While running, wdt_clr=1 zeroes the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| sleep_req | input | 1 | Sleep instruction executed |
| wdt_clr | input | 1 | Watchdog clear instruction |
| wdt_en | input | 1 | Watchdog enable |
| ext_rst | input | 1 | External reset request, synchronous |
| wk_glob_en | input | 1 | Global pin wake enable |
| wk_pin_en | input | NPIN | Per-pin wake enables |
| wk_pin | input | NPIN | Wake pin levels, low wakes |
| osc_en | output | 1 | Oscillator enable |
| core_run | output | 1 | Core allowed to execute |
| core_rst | output | 1 | Core held in reset (restart wake) |
| io_hold | output | 1 | Freeze output pins |
| pd_flag | output | 1 | Power-down flag |
| to_flag | output | 1 | Timeout flag |

## Verification
The assertions check on every cycle that osc_en=0 rules out core_run, that a sleep request from the running state produces the entry flag values, and that pd_flag never rises after power-up. They also check that a to_flag fall always comes with a core reset and that ext_rst is always followed by core reset. The bench scenarios cover what depends on counts and ordering: the exact length of the stabilization window, watchdog expiry at exactly WDT_LIMIT edges after entry, the effect of wdt_clr while running, pins ignored when either enable is missing, and reset priority over a simultaneous pin wake.

// File: rtl/slw_pkg.sv
package slw_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAIT  = 2'd2
    } slw_state_e;

    typedef struct packed {
        slw_state_e st;
        logic       restart;
        logic       pd;
        logic       to;
    } slw_ctl_s;
endpackage

// File: rtl/slw_wake_src.sv
module slw_wake_src #(
    parameter int NPIN = 12
) (
    input  logic            glob_en,
    input  logic [NPIN-1:0] pin_en,
    input  logic [NPIN-1:0] pin,
    output logic            wake
);
    logic [NPIN-1:0] hit;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign hit[i] = pin_en[i] & ~pin[i];
    end

    assign wake = glob_en & (|hit);
endmodule

// File: rtl/slw_wdt.sv
module slw_wdt #(
    parameter int WDT_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tmo
);
    localparam int WW = $clog2(WDT_LIMIT + 1);

    logic [WW-1:0] cnt_d, cnt_q;

    assign tmo = run && !clr && (cnt_q == WW'(WDT_LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run)
            cnt_d = tmo ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/slw_settle.sv
module slw_settle #(
    parameter int SETTLE_CYC = 40,
    parameter int TAIL_CYC   = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clr,
    output logic done
);
    localparam int TOTAL = SETTLE_CYC + TAIL_CYC;
    localparam int DW    = $clog2(TOTAL + 1);

    logic [DW-1:0] cnt_d, cnt_q;

    assign done = active && !clr && (cnt_q == DW'(TOTAL - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !active)
            cnt_d = '0;
        else if (!done)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import slw_pkg::*;
#(
    parameter int NPIN       = 12,
    parameter int WDT_LIMIT  = 64,
    parameter int SETTLE_CYC = 40,
    parameter int TAIL_CYC   = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic            wdt_clr,
    input  logic            wdt_en,
    input  logic            ext_rst,
    input  logic            wk_glob_en,
    input  logic [NPIN-1:0] wk_pin_en,
    input  logic [NPIN-1:0] wk_pin,
    output logic            osc_en,
    output logic            core_run,
    output logic            core_rst,
    output logic            io_hold,
    output logic            pd_flag,
    output logic            to_flag
);
    slw_ctl_s c_d, c_q;
    logic     pin_wake, wdt_tmo, wdt_run, wdt_zero, settle_done;

    slw_wake_src #(.NPIN(NPIN)) u_src (
        .glob_en (wk_glob_en),
        .pin_en  (wk_pin_en),
        .pin     (wk_pin),
        .wake    (pin_wake)
    );

    assign wdt_run  = wdt_en && (c_q.st == ST_RUN || c_q.st == ST_SLEEP);
    assign wdt_zero = ext_rst || (c_q.st == ST_WAIT) ||
                      (c_q.st == ST_RUN && (wdt_clr || sleep_req));

    slw_wdt #(.WDT_LIMIT(WDT_LIMIT)) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wdt_run),
        .clr   (wdt_zero),
        .tmo   (wdt_tmo)
    );

    slw_settle #(.SETTLE_CYC(SETTLE_CYC), .TAIL_CYC(TAIL_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (c_q.st == ST_WAIT),
        .clr    (ext_rst),
        .done   (settle_done)
    );

    always_comb begin
        c_d = c_q;
        if (ext_rst) begin
            c_d.st      = ST_WAIT;
            c_d.restart = 1'b1;
        end else if (wdt_tmo) begin
            c_d.st      = ST_WAIT;
            c_d.restart = 1'b1;
            c_d.to      = 1'b0;
        end else begin
            unique case (c_q.st)
                ST_RUN: begin
                    if (sleep_req) begin
                        c_d.st = ST_SLEEP;
                        c_d.pd = 1'b0;
                        c_d.to = 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (pin_wake) begin
                        c_d.st      = ST_WAIT;
                        c_d.restart = 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (settle_done) begin
                        c_d.st      = ST_RUN;
                        c_d.restart = 1'b0;
                    end
                end
                default: c_d.st = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st      <= ST_WAIT;
            c_q.restart <= 1'b1;
            c_q.pd      <= 1'b1;
            c_q.to      <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign osc_en   = (c_q.st != ST_SLEEP);
    assign core_run = (c_q.st == ST_RUN);
    assign core_rst = (c_q.st == ST_WAIT) && c_q.restart;
    assign io_hold  = (c_q.st == ST_SLEEP);
    assign pd_flag  = c_q.pd;
    assign to_flag  = c_q.to;
endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic ext_rst,
    input logic osc_en,
    input logic core_run,
    input logic core_rst,
    input logic pd_flag,
    input logic to_flag
);
    // R2
    osc_off_core_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !core_run);

    // R2
    sleep_entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_run && sleep_req && !ext_rst |=> !osc_en && !pd_flag && to_flag);

    // R4
    pd_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(pd_flag));

    // R5
    to_fall_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(to_flag) |-> core_rst);

    // R6
    ext_rst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> core_rst && !core_run);
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .ext_rst   (ext_rst),
    .osc_en    (osc_en),
    .core_run  (core_run),
    .core_rst  (core_rst),
    .pd_flag   (pd_flag),
    .to_flag   (to_flag)
);

// File: tb/sim_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_wake_ctrl;
    localparam int NPIN  = 12;
    localparam int LIM   = 64;
    localparam int SETL  = 40;
    localparam int TAIL  = 128;
    localparam int TOT   = SETL + TAIL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 0, wdt_clr = 0, wdt_en = 0, ext_rst = 0, wk_glob_en = 0;
    logic [NPIN-1:0] wk_pin_en = '0;
    logic [NPIN-1:0] wk_pin = '1;
    logic osc_en, core_run, core_rst, io_hold, pd_flag, to_flag;

    always #5 clk = ~clk;

    sleep_wake_ctrl #(.NPIN(NPIN), .WDT_LIMIT(LIM), .SETTLE_CYC(SETL), .TAIL_CYC(TAIL)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wdt_clr(wdt_clr),
        .wdt_en(wdt_en), .ext_rst(ext_rst), .wk_glob_en(wk_glob_en),
        .wk_pin_en(wk_pin_en), .wk_pin(wk_pin), .osc_en(osc_en),
        .core_run(core_run), .core_rst(core_rst), .io_hold(io_hold),
        .pd_flag(pd_flag), .to_flag(to_flag)
    );

    // reference model: 0 running, 1 asleep, 2 waiting
    int m_st = 2, m_dly = 0, m_wdt = 0;
    bit m_rest = 1, m_pd = 1, m_to = 1;
    int vectors = 0, fails = 0, cycles = 0;

    task automatic model_tick();
        bit pw, cnt, zc, tmo;
        if (!rst_n) begin
            m_st = 2; m_rest = 1; m_pd = 1; m_to = 1; m_dly = 0; m_wdt = 0;
            return;
        end
        pw  = wk_glob_en && ((wk_pin_en & ~wk_pin) != 0);
        cnt = wdt_en && (m_st == 0 || m_st == 1);
        zc  = ext_rst || m_st == 2 || (m_st == 0 && (wdt_clr || sleep_req));
        tmo = cnt && !zc && (m_wdt == LIM - 1);
        if (zc) m_wdt = 0;
        else if (cnt) m_wdt = tmo ? 0 : m_wdt + 1;
        if (ext_rst) begin
            m_st = 2; m_rest = 1; m_dly = 0;
        end else if (tmo) begin
            m_st = 2; m_rest = 1; m_dly = 0; m_to = 0;
        end else if (m_st == 0 && sleep_req) begin
            m_st = 1; m_pd = 0; m_to = 1;
        end else if (m_st == 1 && pw) begin
            m_st = 2; m_rest = 0; m_dly = 0;
        end else if (m_st == 2) begin
            if (m_dly == TOT - 1) begin m_st = 0; m_rest = 0; m_dly = 0; end
            else m_dly++;
        end
    endtask

    task automatic cmp1(string req, string nm, logic act, bit exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        cmp1("R10", "osc_en",   osc_en,   m_st != 1);
        cmp1("R8",  "core_run", core_run, m_st == 0);
        cmp1("R6",  "core_rst", core_rst, m_st == 2 && m_rest);
        cmp1("R10", "io_hold",  io_hold,  m_st == 1);
        cmp1("R4",  "pd_flag",  pd_flag,  m_pd);
        cmp1("R5",  "to_flag",  to_flag,  m_to);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_tick();
            #1;
            compare_all();
        end
    endtask

    task automatic chk(string req, string nm, logic act, logic exp);
        cmp1(req, nm, act, exp);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1; step(); sleep_req = 0;
    endtask

    task automatic pulse_ext();
        ext_rst = 1; step(); ext_rst = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1 power-up state
        step(3);
        chk("R1", "pd_flag", pd_flag, 1); chk("R1", "to_flag", to_flag, 1);
        chk("R1", "core_run", core_run, 0); chk("R1", "core_rst", core_rst, 1);
        chk("R1", "osc_en", osc_en, 1);
        rst_n = 1;
        step(TOT - 1);
        chk("R8", "core_run before window end", core_run, 0);
        step();
        chk("R1", "core_run after window", core_run, 1);
        step(5);

        // R2 sleep entry
        pulse_sleep();
        chk("R2", "osc_en", osc_en, 0); chk("R2", "pd_flag", pd_flag, 0);
        chk("R2", "to_flag", to_flag, 1); chk("R10", "io_hold", io_hold, 1);

        // R7 pin low without per-pin enable, then without global enable
        wk_pin[3] = 0; wk_glob_en = 1; step(6);
        chk("R7", "no wake w/o pin enable", io_hold, 1);
        wk_glob_en = 0; wk_pin_en[3] = 1; step(6);
        chk("R7", "no wake w/o global enable", io_hold, 1);
        wk_glob_en = 1; step();
        chk("R7", "pin wake no reset", core_rst, 0);
        chk("R10", "io_hold released", io_hold, 0);
        wk_pin = '1;
        step(TOT - 1);
        chk("R8", "pin wake window", core_run, 0);
        step();
        chk("R8", "resume after window", core_run, 1);
        chk("R4", "pd kept after pin wake", pd_flag, 0);

        // R11 wdt_clr keeps running core alive
        wdt_en = 1;
        for (int k = 0; k < 6; k++) begin
            step(LIM - 10); wdt_clr = 1; step(); wdt_clr = 0;
        end
        chk("R11", "no timeout with clears", core_run, 1);

        // R3 timeout while asleep
        pulse_sleep();
        step(LIM - 1);
        chk("R3", "still asleep before limit", io_hold, 1);
        step();
        chk("R3", "timeout wakes with reset", core_rst, 1);
        chk("R5", "to cleared", to_flag, 0);
        wdt_en = 0;
        step(TOT);
        chk("R8", "run after wdt wake", core_run, 1);

        // R5 timeout while running
        wdt_en = 1; step(5); pulse_sleep(); wk_pin_en = '0;
        wk_pin_en[0] = 1; wk_pin[0] = 0; step(); wk_pin = '1;
        step(TOT);
        chk("R5", "to set by sleep", to_flag, 1);
        step(LIM);
        chk("R5", "awake timeout reset", core_rst, 1);
        chk("R5", "awake timeout to", to_flag, 0);
        wdt_en = 0; step(TOT);

        // R6 external reset from sleep, and restart within window
        pulse_sleep(); step(4);
        pulse_ext();
        chk("R6", "ext wake reset", core_rst, 1);
        step(50); pulse_ext();
        step(TOT - 1);
        chk("R6", "window restarted", core_run, 0);
        step();
        chk("R6", "run after restarted window", core_run, 1);
        chk("R4", "pd kept after ext reset", pd_flag, 0);

        // R9 reset beats simultaneous pin wake
        pulse_sleep(); step(3);
        wk_pin[0] = 0; ext_rst = 1; step(); ext_rst = 0; wk_pin = '1;
        chk("R9", "reset priority", core_rst, 1);
        step(TOT);

        // R11 disabled watchdog never expires in sleep
        pulse_sleep(); step(3 * LIM);
        chk("R11", "no wdt wake when disabled", io_hold, 1);
        wk_pin[0] = 0; step(); wk_pin = '1;
        chk("R7", "pin wake after long sleep", core_rst, 0);
        step(TOT + 4);
        chk("R8", "final run", core_run, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule